// File: doc/BRIEF.md
# Alarmed Seconds Counter with Settling Status

This block keeps a 32-bit count of seconds that advances once for every pulse on a one-per-second `tick` input. Software sets the time, programs an alarm, masks the alarm interrupt and acknowledges it through a small register port. The port writes on the fast bus clock. The counter and the interrupt logic change only on tick edges. Each write therefore crosses over gradually.

Four kinds of write reach the tick side: loading the time, changing the alarm, acknowledging the interrupt and changing the mask. Each has its own toggle request and its own in-progress status bit. A write takes effect on the `XFER_TICKS`-th tick after it. Until then its status bit stays set, and the registers on the tick side keep their old values. The load register reads back the last value written to it, not the running time.

Top module: `rtc_sync_core`

## Requirements
- R1: After reset the time is 0, the alarm is all ones, the load readback is 0, the mask is 0, the raw and masked interrupt are 0, the status reads 0 and `irq` is low.
- R2: The time (address 0) increases by exactly one on each `tick` that does not complete a load. It never changes without a tick. Writes to address 0 have no effect.
- R3: A write to the load register (address 2) sets status bit 0 from the next cycle on. Until the `XFER_TICKS`-th tick after the write, the time keeps counting from its old value. On that tick the time becomes the written value, with no increment, and status bit 0 clears.
- R4: Reading address 2 returns the last value written there, starting from the cycle after the write.
- R5: A write to the alarm register (address 1) sets status bit 1. The alarm readback changes to the new value on the `XFER_TICKS`-th tick after the write, and bit 1 clears on that same tick.
- R6: On a counting tick where the time equals the alarm, so that the count reaches alarm+1, the raw interrupt (address 6, bit 0) is set. It stays set until an acknowledge completes.
- R7: The mask register is bit 0 of address 3. A write to it sets status bit 3 and takes effect on the `XFER_TICKS`-th tick. The masked interrupt (address 4, bit 0) and the `irq` output equal raw AND mask.
- R8: Writing a value with bit 0 set to address 4 sets status bit 2 and clears the raw interrupt on the `XFER_TICKS`-th tick. If an alarm hit falls on that same tick, the hit wins. A write to address 4 with bit 0 clear is ignored.
- R9: A write to a register whose transfer is still pending replaces the pending value and restarts the tick count from zero.
- R10: Address 5 reads the status bits in the order load, alarm, acknowledge, mask, from bit 0 up. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | TW | Write data |
| rdata | output | TW | Read data, combinational from addr |
| irq | output | 1 | Masked alarm interrupt |

## Verification
A transfer counter or toggle pair that has drifted shows at the ports in the status word and in the register it guards. The bit stays set, or clears one tick early or late, and the time, alarm or mask readback changes on the wrong tick. A wrong compare shows as a raw interrupt set one second off, or not at all. Since every register is compared after every cycle, a fault appears at the first tick where the model and the design part ways.

// File: rtl/rtc_sync_core.sv
module rtc_sync_core #(
  parameter int TW         = 32,
  parameter int XFER_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  output logic          irq
);
  localparam int CW = $clog2(XFER_TICKS) + 1;
  localparam logic [CW-1:0] LAST = CW'(XFER_TICKS - 1);

  logic [TW-1:0] time_q, alarm_q, ld_val, al_val;
  logic          raw_q, mask_q, mk_val;
  logic [3:0]    req_t, ack_t, busy, wr_op, done;
  logic [CW-1:0] cnt [4];

  assign wr_op[0] = wr_en && addr == 3'd2;
  assign wr_op[1] = wr_en && addr == 3'd1;
  assign wr_op[2] = wr_en && addr == 3'd4 && wdata[0];
  assign wr_op[3] = wr_en && addr == 3'd3;
  assign busy     = req_t ^ ack_t;

  for (genvar i = 0; i < 4; i++) begin : g_xfer
    assign done[i] = tick && busy[i] && !wr_op[i] && cnt[i] == LAST;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_t[i] <= 1'b0;
        ack_t[i] <= 1'b0;
        cnt[i]   <= '0;
      end else if (wr_op[i]) begin
        req_t[i] <= req_t[i] ^ ~busy[i];
        cnt[i]   <= '0;
      end else if (tick && busy[i]) begin
        if (cnt[i] == LAST) begin
          ack_t[i] <= ~ack_t[i];
          cnt[i]   <= '0;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_val <= '0;
      al_val <= '0;
      mk_val <= 1'b0;
    end else begin
      if (wr_op[0]) ld_val <= wdata;
      if (wr_op[1]) al_val <= wdata;
      if (wr_op[3]) mk_val <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q  <= '0;
      alarm_q <= '1;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (done[0])   time_q <= ld_val;
      else if (tick) time_q <= time_q + 1'b1;
      if (done[1]) alarm_q <= al_val;
      if (done[3]) mask_q  <= mk_val;
      if (tick && !done[0] && time_q == alarm_q) raw_q <= 1'b1;
      else if (done[2])                          raw_q <= 1'b0;
    end
  end

  assign irq = raw_q & mask_q;

  always_comb begin
    case (addr)
      3'd0:    rdata = time_q;
      3'd1:    rdata = alarm_q;
      3'd2:    rdata = ld_val;
      3'd3:    rdata = {{(TW-1){1'b0}}, mask_q};
      3'd4:    rdata = {{(TW-1){1'b0}}, irq};
      3'd5:    rdata = {{(TW-4){1'b0}}, busy};
      3'd6:    rdata = {{(TW-1){1'b0}}, raw_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sync_core_chk.sv
module rtc_sync_core_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [TW-1:0] wdata,
  input logic [TW-1:0] time_q,
  input logic [TW-1:0] ld_val,
  input logic          raw_q,
  input logic          mask_q,
  input logic [3:0]    busy
);
  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q));
  assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> busy[0]);
  assert_load_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> $past(tick));
  assert_load_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> ld_val == $past(wdata));
  assert_alarm_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> busy[1]);
  assert_raw_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(tick));
  assert_mask_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mask_q));
  assert_ack_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && !wdata[0] && !busy[2]) |=> !busy[2]);
  assert_raw_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw_q) |-> $past(tick));
endmodule

bind rtc_sync_core rtc_sync_core_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .time_q(time_q), .ld_val(ld_val), .raw_q(raw_q),
  .mask_q(mask_q), .busy(busy)
);

// File: tb/rtc_sync_core_bench.sv
`timescale 1ns/100ps
module rtc_sync_core_bench;
  localparam int TW = 32;
  localparam int XT = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, irq;
  logic [2:0] addr = '0;
  logic [TW-1:0] wdata = '0, rdata;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  rtc_sync_core #(.TW(TW), .XFER_TICKS(XT)) u_rtc_sync_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  // reference model state
  logic [TW-1:0] m_time, m_alarm, m_ld, m_al;
  logic m_raw, m_mask, m_mk;
  logic [3:0] m_pend;
  int m_cnt [4];

  task automatic model_reset();
    m_time = 0; m_alarm = '1; m_ld = 0; m_al = 0;
    m_raw = 0; m_mask = 0; m_mk = 0; m_pend = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
  endtask

  task automatic model_edge(input logic w, input logic [2:0] a,
                            input logic [TW-1:0] d, input logic t);
    logic [3:0] op, dn;
    op[0] = w && a == 2; op[1] = w && a == 1;
    op[2] = w && a == 4 && d[0]; op[3] = w && a == 3;
    for (int i = 0; i < 4; i++)
      dn[i] = t && m_pend[i] && !op[i] && m_cnt[i] == XT - 1;
    if (t && !dn[0] && m_time == m_alarm) m_raw = 1;
    else if (dn[2]) m_raw = 0;
    if (dn[0]) m_time = m_ld; else if (t) m_time = m_time + 1;
    if (dn[1]) m_alarm = m_al;
    if (dn[3]) m_mask = m_mk;
    for (int i = 0; i < 4; i++) begin
      if (op[i]) begin m_pend[i] = 1; m_cnt[i] = 0; end
      else if (t && m_pend[i]) begin
        if (m_cnt[i] == XT - 1) begin m_pend[i] = 0; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
    end
    if (op[0]) m_ld = d;
    if (op[1]) m_al = d;
    if (op[3]) m_mk = d[0];
  endtask

  task automatic expect_eq(input string tag, input logic [TW-1:0] act,
                           input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [TW-1:0] v);
    addr = a; #0.2; v = rdata;
  endtask

  task automatic check_all();
    logic [TW-1:0] v;
    peek(0, v); expect_eq("R2 time", v, m_time);
    peek(1, v); expect_eq("R5 alarm", v, m_alarm);
    peek(2, v); expect_eq("R4 load readback", v, m_ld);
    peek(3, v); expect_eq("R7 mask", v, {31'b0, m_mask});
    peek(4, v); expect_eq("R7 masked int", v, {31'b0, m_raw & m_mask});
    peek(5, v); expect_eq("R10 status", v, {28'b0, m_pend});
    peek(6, v); expect_eq("R6 raw int", v, {31'b0, m_raw});
    peek(7, v); expect_eq("R10 unused addr", v, '0);
    expect_eq("R7 irq", {31'b0, irq}, {31'b0, m_raw & m_mask});
  endtask

  // called at a negedge; drives one cycle, then checks after the next negedge
  task automatic step(input logic w, input logic [2:0] a,
                      input logic [TW-1:0] d, input logic t);
    wr_en = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_edge(w, a, d, t);
    @(negedge clk);
    wr_en = 0; tick = 0;
    check_all();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    check_all();
    peek(1, v); expect_eq("R1 alarm reset", v, '1);
    peek(5, v); expect_eq("R1 status reset", v, '0);

    // R2: write to time is ignored, ticks count
    step(1, 0, 32'h1234, 0);
    peek(0, v); expect_eq("R2 time write ignored", v, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    peek(0, v); expect_eq("R2 two ticks", v, 2);

    // R3/R4: load with delay
    step(1, 2, 32'h100, 0);
    peek(2, v); expect_eq("R4 readback", v, 32'h100);
    peek(5, v); expect_eq("R3 load pending", v, 1);
    step(0, 0, 0, 1);
    peek(0, v); expect_eq("R3 old count kept", v, 3);
    // R9: rewrite restarts the transfer
    step(1, 2, 32'h200, 0);
    step(0, 0, 0, 1);
    peek(0, v); expect_eq("R9 restart not applied", v, 4);
    peek(5, v); expect_eq("R9 still pending", v, 1);
    step(0, 0, 0, 1);
    peek(0, v); expect_eq("R9 new value applied", v, 32'h200);
    peek(5, v); expect_eq("R3 pending cleared", v, 0);

    // R5/R6/R7: alarm hit and mask
    step(1, 1, 32'h203, 0);
    step(1, 3, 1, 0);
    peek(5, v); expect_eq("R10 alarm+mask pending", v, 32'hA);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    peek(1, v); expect_eq("R5 alarm applied", v, 32'h203);
    step(0, 0, 0, 1);
    peek(6, v); expect_eq("R6 no early hit", v, 0);
    step(0, 0, 0, 1);
    peek(0, v); expect_eq("R6 count past alarm", v, 32'h204);
    peek(6, v); expect_eq("R6 hit", v, 1);
    expect_eq("R7 irq asserted", {31'b0, irq}, 1);

    // R8: ack with bit 0 clear ignored, then real ack
    step(1, 4, 0, 0);
    peek(5, v); expect_eq("R8 zero ack ignored", v, 0);
    step(1, 4, 1, 0);
    peek(5, v); expect_eq("R8 ack pending", v, 4);
    step(0, 0, 0, 1);
    peek(6, v); expect_eq("R8 raw held", v, 1);
    step(0, 0, 0, 1);
    peek(6, v); expect_eq("R8 raw cleared", v, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [TW-1:0] d;
      logic t;
      r = $urandom_range(0, 9);
      t = ($urandom_range(0, 2) == 0);
      case (r)
        0: step(1, 2, m_time + $urandom_range(0, 6), t);
        1: step(1, 1, m_time + $urandom_range(0, 5), t);
        2: step(1, 3, $urandom_range(0, 1), t);
        3: step(1, 4, $urandom_range(0, 1), t);
        4: begin d = $urandom; step(1, 3'($urandom_range(0, 7)), d, t); end
        default: step(0, 0, 0, t);
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule